// File: doc/BRIEF.md
# Color Lookup Table with Sequenced Component Loading

This block holds a 256-entry color palette and turns 8-bit pixel codes into packed 24-bit colors. A host fills the palette through a small byte-addressed write port that has two registers. The index register picks the palette entry where loading starts. The color register takes the red, green and blue values of each entry one after another.

A three-state component sequencer steers every color byte to the correct bank. After the blue byte of an entry, it moves on to the next entry without host help, so a whole palette loads with one index write followed by a stream of color bytes. A write to the color register may carry one byte or a full 32-bit word. A word is split into four component bytes, most significant byte first, so the load stays packed even when the bytes cross entry boundaries.

On the display side, a registered lookup port returns the color of any entry one cycle after its code is presented. A sticky redraw flag tells the display logic that the palette has changed since it last cleared the flag.

Top module: `clut_loader`

## Requirements
- R1: `bus_rdata` is zero at all times, so a read of the index register (offset 0x0) or of the color register (offset 0x4) returns zero.
- R2: A write to offset 0x0 loads `bus_wdata[7:0]` into the entry index and puts the component state back to red (state code 0), even when it arrives in the middle of an entry.
- R3: Each color byte is stored in the component that the current state selects: code 0 is red, 1 is green, 2 is blue. The lookup result packs red into bits 23:16, green into bits 15:8 and blue into bits 7:0.
- R4: After a blue byte, the entry index increases by one modulo 256 (255 goes to 0) and the state returns to red.
- R5: A color write with `bus_wide`=1 delivers four components from `bus_wdata[31:24]` down to `bus_wdata[7:0]`. Each byte advances the state and, after blue, the index. With `bus_wide`=0 only `bus_wdata[7:0]` is used.
- R6: Every color write sets `redraw`. `redraw_clr` clears it. When a color write and `redraw_clr` arrive in the same cycle, the flag stays set. A write to the index register does not change the flag.
- R7: Reset makes every component of every entry zero, sets the index to 0 and the state to red, and sets `redraw`.
- R8: `pix_rgb` shows the entry addressed by `pix_idx` one cycle later. If a palette write hits the same entry in the same cycle as the lookup, the lookup returns the value from before the write.
- R9: A write to any offset other than 0x0 or 0x4 changes no palette entry, no index, no state and no redraw flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wide | input | 1 | 1: four-byte write, 0: single-byte write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| redraw_clr | input | 1 | Clears the redraw flag |
| redraw | output | 1 | Sticky flag: the palette changed |
| pix_idx | input | 8 | Pixel code to look up |
| pix_rgb | output | 24 | Packed color, one cycle after `pix_idx` |
| dbg_index | output | 8 | Current entry index of the loader |
| dbg_phase | output | 2 | Current component state (0 red, 1 green, 2 blue) |

## Verification
Two functions can land in the same cycle. The first case is a pixel lookup of an entry while the loader writes that same entry. The bench provokes it by sending the last blue byte of an entry in the same cycle as a lookup of that entry. It expects the color from before the write, and then expects the new color from a lookup in the next cycle. The second case is a color write together with a redraw clear. In that case the bench expects the flag to stay set after the cycle.

// File: rtl/clut_pkg.sv
package clut_pkg;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    localparam int OFF_INDEX = 0;
    localparam int OFF_COLOR = 4;
    localparam int NUM_COMP  = 3;

    function automatic phase_e ph_next(phase_e p);
        case (p)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int COMP_W = 8,
    localparam int LANES = DATA_W / COMP_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic                              wr_wide,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [LANES-1:0]                  lane_en,
    output logic [LANES-1:0][1:0]             lane_comp,
    output logic [LANES-1:0][IDX_W-1:0]       lane_idx,
    output logic [LANES-1:0][COMP_W-1:0]      lane_data,
    output logic                              color_hit,
    output logic [IDX_W-1:0]                  dbg_idx,
    output logic [1:0]                        dbg_phase
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        phase_e           phase;
    } seq_t;

    seq_t s_d, s_q, run;
    logic index_hit;

    assign index_hit = wr_en && (wr_addr == ADDR_W'(OFF_INDEX));
    assign color_hit = wr_en && (wr_addr == ADDR_W'(OFF_COLOR));

    always_comb begin
        s_d       = s_q;
        run       = s_q;
        lane_en   = '0;
        lane_comp = '0;
        lane_idx  = '0;
        lane_data = '0;
        if (index_hit) begin
            s_d.idx   = wr_data[IDX_W-1:0];
            s_d.phase = PH_RED;
        end else if (color_hit) begin
            for (int k = 0; k < LANES; k++) begin
                if (k == 0 || wr_wide) begin
                    lane_en[k]   = 1'b1;
                    lane_comp[k] = run.phase;
                    lane_idx[k]  = run.idx;
                    lane_data[k] = wr_wide ? wr_data[DATA_W-1-COMP_W*k -: COMP_W]
                                           : wr_data[COMP_W-1:0];
                    if (run.phase == PH_BLU) begin
                        run.idx = run.idx + 1'b1;
                    end
                    run.phase = ph_next(run.phase);
                end
            end
            s_d = run;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{idx: '0, phase: PH_RED};
        end else begin
            s_q <= s_d;
        end
    end

    assign dbg_idx   = s_q.idx;
    assign dbg_phase = s_q.phase;

    // R2: an index write restarts the sequence at red on the written entry
    p_index_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        index_hit |=> (s_q.phase == PH_RED) && (s_q.idx == $past(wr_data[IDX_W-1:0])));

    // R3: the component state never takes the unused code
    p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.phase != 2'd3);

    // R4: a single blue byte moves to the next entry, wrapping modulo the depth
    p_blue_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (color_hit && !wr_wide && s_q.phase == PH_BLU) |=>
        (s_q.phase == PH_RED) && (s_q.idx == IDX_W'($past(s_q.idx) + 1'b1)));

    generate
        if (LANES == 4) begin : g_wide_chk
            // R5: four components advance the three-state sequence by one step
            p_wide_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (color_hit && wr_wide) |=> s_q.phase == ph_next($past(s_q.phase)));
        end
    endgenerate

endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
    parameter int         IDX_W  = 8,
    parameter int         COMP_W = 8,
    parameter int         LANES  = 4,
    parameter logic [1:0] COMP   = 2'd0,
    localparam int        DEPTH  = 1 << IDX_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LANES-1:0]             lane_en,
    input  logic [LANES-1:0][1:0]        lane_comp,
    input  logic [LANES-1:0][IDX_W-1:0]  lane_idx,
    input  logic [LANES-1:0][COMP_W-1:0] lane_data,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [COMP_W-1:0]            rd_q
);

    logic [COMP_W-1:0] mem_q [DEPTH];
    logic [COMP_W-1:0] rd_d;

    always_comb begin
        rd_d = mem_q[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
            for (int k = 0; k < LANES; k++) begin
                if (lane_en[k] && lane_comp[k] == COMP) begin
                    mem_q[lane_idx[k]] <= lane_data[k];
                end
            end
        end
    end

endmodule

// File: rtl/clut_loader.sv
module clut_loader
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int COMP_W = 8,
    localparam int LANES = DATA_W / COMP_W,
    localparam int RGB_W = NUM_COMP * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wide,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              redraw_clr,
    output logic              redraw,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [RGB_W-1:0]  pix_rgb,
    output logic [IDX_W-1:0]  dbg_index,
    output logic [1:0]        dbg_phase
);

    logic [LANES-1:0]             lane_en;
    logic [LANES-1:0][1:0]        lane_comp;
    logic [LANES-1:0][IDX_W-1:0]  lane_idx;
    logic [LANES-1:0][COMP_W-1:0] lane_data;
    logic                         color_hit;
    logic [COMP_W-1:0]            comp_q [NUM_COMP];
    logic                         redraw_d, redraw_q;

    clut_seq #(
        .IDX_W (IDX_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .COMP_W(COMP_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we),
        .wr_addr  (bus_addr),
        .wr_wide  (bus_wide),
        .wr_data  (bus_wdata),
        .lane_en  (lane_en),
        .lane_comp(lane_comp),
        .lane_idx (lane_idx),
        .lane_data(lane_data),
        .color_hit(color_hit),
        .dbg_idx  (dbg_index),
        .dbg_phase(dbg_phase)
    );

    generate
        for (genvar c = 0; c < NUM_COMP; c++) begin : g_bank
            clut_bank #(
                .IDX_W (IDX_W),
                .COMP_W(COMP_W),
                .LANES (LANES),
                .COMP  (2'(c))
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .lane_en  (lane_en),
                .lane_comp(lane_comp),
                .lane_idx (lane_idx),
                .lane_data(lane_data),
                .rd_idx   (pix_idx),
                .rd_q     (comp_q[c])
            );
        end
    endgenerate

    always_comb begin
        redraw_d = redraw_q;
        if (redraw_clr) begin
            redraw_d = 1'b0;
        end
        if (color_hit) begin
            redraw_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redraw_q <= 1'b1;
        end else begin
            redraw_q <= redraw_d;
        end
    end

    assign redraw    = redraw_q;
    assign pix_rgb   = {comp_q[0], comp_q[1], comp_q[2]};
    assign bus_rdata = '0;

    // R6: a color write leaves the flag set on the next cycle, clear or not
    p_redraw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_COLOR)) |=> redraw);

    // R6: a clear with no color write drops the flag
    p_redraw_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (redraw_clr && !(bus_we && bus_addr == ADDR_W'(OFF_COLOR))) |=> !redraw);

    // R9: a write to an unused offset leaves loader state alone
    p_other_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != ADDR_W'(OFF_COLOR) && bus_addr != ADDR_W'(OFF_INDEX) && !redraw_clr)
        |=> $stable(dbg_index) && $stable(dbg_phase) && $stable(redraw));

endmodule

// File: tb/tb_clut_loader.sv
`timescale 1ns/100ps
module tb_clut_loader;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wide = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        redraw_clr = 1'b0;
    logic        redraw;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;
    logic [7:0]  dbg_index;
    logic [1:0]  dbg_phase;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int          due;
        logic [23:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    logic [7:0] m_r [256];
    logic [7:0] m_g [256];
    logic [7:0] m_b [256];
    logic [7:0] m_idx;
    logic [1:0] m_ph;
    logic       m_redraw;

    clut_loader dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .redraw_clr(redraw_clr), .redraw(redraw), .pix_idx(pix_idx),
        .pix_rgb(pix_rgb), .dbg_index(dbg_index), .dbg_phase(dbg_phase)
    );

    always #(HALF) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compares lookup results when they fall due
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.req, {8'h00, pix_rgb}, {8'h00, it.exp});
        end
    end

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            m_r[i] = 8'h00; m_g[i] = 8'h00; m_b[i] = 8'h00;
        end
        m_idx = 8'h00; m_ph = 2'd0; m_redraw = 1'b1;
    endtask

    task automatic model_wr(input logic [4:0] a, input logic [31:0] d, input logic w);
        int n;
        logic [7:0] b;
        if (a == 5'h00) begin
            m_idx = d[7:0];
            m_ph = 2'd0;
        end else if (a == 5'h04) begin
            n = w ? 4 : 1;
            for (int k = 0; k < n; k++) begin
                b = w ? d[31-8*k -: 8] : d[7:0];
                case (m_ph)
                    2'd0: begin m_r[m_idx] = b; m_ph = 2'd1; end
                    2'd1: begin m_g[m_idx] = b; m_ph = 2'd2; end
                    default: begin m_b[m_idx] = b; m_ph = 2'd0; m_idx = m_idx + 8'd1; end
                endcase
            end
            m_redraw = 1'b1;
        end
    endtask

    // driver: one cycle of stimulus; lookups push their expected color
    task automatic drive(input logic we, input logic [4:0] a, input logic [31:0] d,
                         input logic w, input logic clr, input logic lk,
                         input logic [7:0] li, input string req);
        item_t it;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; bus_wide = w; redraw_clr = clr;
        if (lk) begin
            pix_idx = li;
            it.due = cyc + 1;
            it.exp = {m_r[li], m_g[li], m_b[li]};
            it.req = req;
            sb_q.push_back(it);
        end
        if (clr) m_redraw = 1'b0;
        if (we) model_wr(a, d, w);
        @(posedge clk);
        #1;
        bus_we = 1'b0; redraw_clr = 1'b0; bus_wide = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic w);
        drive(1'b1, a, d, w, 1'b0, 1'b0, 8'h00, "");
    endtask

    task automatic lk(input logic [7:0] i, input string req);
        drive(1'b0, 5'h00, 32'h0, 1'b0, 1'b0, 1'b1, i, req);
    endtask

    task automatic chk_state(input string req);
        check(req, {24'h0, dbg_index}, {24'h0, m_idx});
        check(req, {30'h0, dbg_phase}, {30'h0, m_ph});
        check(req, {31'h0, redraw}, {31'h0, m_redraw});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drain();
        for (int i = 0; i < 3; i++) @(negedge clk);
    endtask

    initial begin
        #(HALF * 2 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R7 / R1: state after reset
        check("R7", {24'h0, dbg_index}, 32'h0);
        check("R7", {30'h0, dbg_phase}, 32'h0);
        check("R7", {31'h0, redraw}, 32'h1);
        check("R1", bus_rdata, 32'h0);
        lk(8'h00, "R7"); lk(8'h07, "R7"); lk(8'hFF, "R7");

        // R6: clear, then an index write must not set the flag
        drive(1'b0, 5'h00, 32'h0, 1'b0, 1'b1, 1'b0, 8'h00, "");
        check("R6", {31'h0, redraw}, 32'h0);
        wr(5'h00, 32'h0000_0010, 1'b0);
        check("R2", {24'h0, dbg_index}, 32'h10);
        check("R6", {31'h0, redraw}, 32'h0);

        // R3 / R4: byte writes walk red, green, blue then advance
        wr(5'h04, 32'h0000_0011, 1'b0);
        check("R3", {30'h0, dbg_phase}, 32'h1);
        wr(5'h04, 32'h0000_0022, 1'b0);
        check("R3", {30'h0, dbg_phase}, 32'h2);
        wr(5'h04, 32'hFFFF_FF33, 1'b0);
        check("R4", {24'h0, dbg_index}, 32'h11);
        check("R4", {30'h0, dbg_phase}, 32'h0);
        check("R6", {31'h0, redraw}, 32'h1);
        lk(8'h10, "R3");
        check("R1", bus_rdata, 32'h0);

        // R2: index rewrite mid-entry restarts at red
        wr(5'h00, 32'h0000_0020, 1'b0);
        wr(5'h04, 32'h0000_00AA, 1'b0);
        wr(5'h00, 32'h0000_0020, 1'b0);
        chk_state("R2");
        wr(5'h04, 32'h01, 1'b0); wr(5'h04, 32'h02, 1'b0); wr(5'h04, 32'h03, 1'b0);
        lk(8'h20, "R2");

        // R4: wrap from the last entry
        wr(5'h00, 32'h0000_00FF, 1'b0);
        wr(5'h04, 32'h0E, 1'b0); wr(5'h04, 32'h0F, 1'b0); wr(5'h04, 32'h10, 1'b0);
        check("R4", {24'h0, dbg_index}, 32'h0);
        lk(8'hFF, "R4");

        // R5: word writes from each starting state
        wr(5'h00, 32'h0000_0040, 1'b0);
        wr(5'h04, 32'hA1B2_C3D4, 1'b1);
        chk_state("R5");
        wr(5'h04, 32'h1122_3344, 1'b1);
        chk_state("R5");
        wr(5'h04, 32'h5566_7788, 1'b1);
        check("R5", {24'h0, dbg_index}, 32'h44);
        check("R5", {30'h0, dbg_phase}, 32'h0);
        lk(8'h40, "R5"); lk(8'h41, "R5"); lk(8'h42, "R5"); lk(8'h43, "R5");
        // R5: word write crossing the wrap
        wr(5'h00, 32'h0000_00FF, 1'b0);
        wr(5'h04, 32'h0102_0304, 1'b1);
        check("R5", {24'h0, dbg_index}, 32'h0);
        check("R5", {30'h0, dbg_phase}, 32'h1);
        lk(8'hFF, "R5"); lk(8'h00, "R5");

        // R9: other offsets are ignored
        drive(1'b0, 5'h00, 32'h0, 1'b0, 1'b1, 1'b0, 8'h00, "");
        wr(5'h08, 32'hDEAD_BEEF, 1'b1);
        wr(5'h0C, 32'h0000_0077, 1'b0);
        wr(5'h05, 32'h0000_0066, 1'b0);
        chk_state("R9");
        lk(8'h00, "R9"); lk(8'h10, "R9");

        // R6: color write and clear in the same cycle keeps the flag
        drive(1'b1, 5'h04, 32'h0000_0099, 1'b0, 1'b1, 1'b0, 8'h00, "");
        check("R6", {31'h0, redraw}, 32'h1);

        // R8: lookup and write of the same entry in one cycle
        wr(5'h00, 32'h0000_0010, 1'b0);
        wr(5'h04, 32'hAA, 1'b0); wr(5'h04, 32'hBB, 1'b0);
        drive(1'b1, 5'h04, 32'h0000_00CC, 1'b0, 1'b0, 1'b1, 8'h10, "R8");
        lk(8'h10, "R8");
        lk(8'h11, "R8"); lk(8'h20, "R8"); lk(8'h41, "R8");
        drain();

        // R7: reset in mid-run wipes everything
        do_reset();
        chk_state("R7");
        lk(8'h10, "R7"); lk(8'h40, "R7"); lk(8'hFF, "R7");
        drain();

        check("R8", sb_q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule